// File: doc/BRIEF.md
# Locked Atomic Read-Modify-Write Unit

This unit sits between one requester and a single-port memory that several masters reach through a shared arbiter. It carries out one atomic operation at a time: swap, fetch-and-add, compare-and-swap, bitwise AND, OR and XOR. It also carries out plain loads and stores. For a locked operation it raises a bus-lock output before its first memory beat and keeps it high until its last write is acknowledged. An arbiter that honours the lock therefore lets no other master touch memory between the read and the write.

The requester supplies an opcode, a byte address, a size of 1, 2, 4 or 8 bytes, an operand and a compare value. The unit answers with the old memory value and a success flag. Memory is 64 bits wide with byte strobes, and data are little-endian. An access that crosses a 64-bit word boundary takes two reads and two writes. An access whose bytes fall in two different cache lines (64 bytes by default) is also a split-lock access. It is flagged in the response and counted by a wrapping event counter.

Top module: `amo_lock_unit`

## Requirements
- R1: For a locked operation, `bus_lock` rises in the cycle after acceptance, one cycle before the first read request. It stays high on every memory beat up to and including the last write acknowledge. It falls in the next cycle, which is the cycle in which `resp_valid` is high.
- R2: Opcode 2 (swap) is always locked, whatever the value of `req_lock`. It writes the operand and returns the previous memory value.
- R3: Opcode 4 (compare-and-swap) compares memory with `req_expect` at the access width. When they are equal it writes the operand and sets `resp_ok`=1. Otherwise memory is left unchanged and `resp_ok`=0. The old value is returned in both cases.
- R4: Opcode 3 (fetch-and-add) returns the old value and writes old plus operand, wrapping modulo the access width. `req_size` 0/1/2/3 selects 1/2/4/8 bytes.
- R5: Opcodes 5/6/7 write old AND, OR and XOR operand, and return the old value.
- R6: A request with `req_lock`=1 and opcode 0 (load) or 1 (store) is rejected. `resp_err`=1 and `resp_ok`=0, no memory beat is issued and `bus_lock` never rises.
- R7: A read-modify-write with `req_lock`=0 other than swap reads and then writes with `bus_lock` low throughout. A load returns the old value and performs no write.
- R8: An accepted access with (address mod line size) + bytes > line size sets `resp_split`=1. It increments `split_count` exactly once and issues four beats: read low word, read high word, write low word, write high word. A locked split access keeps `bus_lock` high on all four beats.
- R9: An access that crosses a 64-bit word boundary inside one line issues four beats, reports `resp_split`=0 and leaves `split_count` unchanged. Only the addressed bytes are written.
- R10: After reset `req_ready`=1, and `bus_lock`, `mem_req` and `resp_valid` are 0, with `split_count`=0. While `req_ready` is high no memory request and no lock are driven.
- R11: Two units sharing memory through an arbiter that keeps a locked master granted lose no increments when they run concurrent locked fetch-and-adds on one address.
- R12: `resp_valid` is a single-cycle pulse. `resp_ok`=1 for every accepted operation other than a failed compare-and-swap. A store returns an old value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 3 | 0 load, 1 store, 2 swap, 3 add, 4 compare-and-swap, 5 AND, 6 OR, 7 XOR |
| req_lock | input | 1 | Ask for the operation to be locked |
| req_size | input | 2 | Access size, 2^n bytes |
| req_addr | input | ADDR_W | Byte address |
| req_operand | input | 64 | Operand or new value, low bits used |
| req_expect | input | 64 | Compare value for compare-and-swap |
| resp_valid | output | 1 | Response pulse |
| resp_old | output | 64 | Previous memory value, zero-extended |
| resp_ok | output | 1 | Success flag |
| resp_err | output | 1 | Request rejected |
| resp_split | output | 1 | Access crossed a cache-line boundary |
| split_count | output | CNT_W | Wrapping count of split-lock accesses |
| bus_lock | output | 1 | Exclusive bus hold for the arbiter |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W-3 | 64-bit word index |
| mem_wdata | output | 64 | Write data |
| mem_wstrb | output | 8 | Byte write enables |
| mem_ack | input | 1 | Beat acknowledge; read data valid with it |
| mem_rdata | input | 64 | Read data |

## Verification
A locked request shows `bus_lock` one cycle after acceptance and a read request one cycle later. Every acknowledge moves the unit to its next beat on the following cycle, and the response appears one cycle after the last write acknowledge. A rejected request answers in the cycle right after acceptance. The lock-timing test steps one falling edge at a time through that sequence against an arbiter whose memory acknowledges one cycle after it takes a request. The other tests poll `resp_valid` at falling edges, check the pulse is gone one cycle later, and compare memory words once the response has been seen.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int WORD_BYTES = 8;
    localparam int WORD_BITS  = 64;
    localparam int OFF_W      = 3;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_ADD   = 3'd3,
        OP_CAS   = 3'd4,
        OP_AND   = 3'd5,
        OP_OR    = 3'd6,
        OP_XOR   = 3'd7
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK,
        ST_RD0,
        ST_RD1,
        ST_WR0,
        ST_WR1,
        ST_DONE
    } amo_state_e;

    typedef struct packed {
        amo_op_e          op;
        logic [1:0]       size;
        logic [OFF_W-1:0] off;
        logic             locked;
        logic             two_word;
        logic             split;
    } amo_ctl_t;

    function automatic logic [3:0] size_bytes(input logic [1:0] s);
        return 4'd1 << s;
    endfunction

    function automatic logic [WORD_BYTES-1:0] byte_mask(input logic [1:0] s);
        case (s)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [WORD_BITS-1:0] data_mask(input logic [1:0] s);
        case (s)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic is_plain(input amo_op_e op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction

endpackage

// File: rtl/amo_addr_decode.sv
module amo_addr_decode
    import amo_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [1:0]              size,
    output logic [OFF_W-1:0]        off,
    output logic [ADDR_W-OFF_W-1:0] widx,
    output logic                    two_word,
    output logic                    split
);
    localparam int LOFF_W = $clog2(LINE_BYTES);

    logic [LOFF_W-1:0] line_off;
    logic [LOFF_W:0]   line_end;
    logic [3:0]        word_end;

    always_comb begin
        off      = addr[OFF_W-1:0];
        widx     = addr[ADDR_W-1:OFF_W];
        line_off = addr[LOFF_W-1:0];
        word_end = {1'b0, off} + size_bytes(size);
        line_end = {1'b0, line_off} + (LOFF_W+1)'(size_bytes(size));
        two_word = word_end > 4'd8;
        split    = line_end > (LOFF_W+1)'(LINE_BYTES);
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_op_e              op,
    input  logic [1:0]           size,
    input  logic [WORD_BITS-1:0] old_val,
    input  logic [WORD_BITS-1:0] operand,
    input  logic [WORD_BITS-1:0] expect_v,
    output logic [WORD_BITS-1:0] new_val,
    output logic                 cas_hit
);
    logic [WORD_BITS-1:0] m;
    logic [WORD_BITS-1:0] opm;

    always_comb begin
        m       = data_mask(size);
        opm     = operand & m;
        cas_hit = (old_val & m) == (expect_v & m);
        case (op)
            OP_STORE,
            OP_SWAP: new_val = opm;
            OP_ADD:  new_val = (old_val + opm) & m;
            OP_CAS:  new_val = cas_hit ? opm : old_val;
            OP_AND:  new_val = old_val & opm;
            OP_OR:   new_val = old_val | opm;
            OP_XOR:  new_val = old_val ^ opm;
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/amo_lane.sv
module amo_lane
    import amo_pkg::*;
(
    input  logic [OFF_W-1:0]      off,
    input  logic [1:0]            size,
    input  logic [WORD_BITS-1:0]  lo_word,
    input  logic [WORD_BITS-1:0]  hi_word,
    input  logic [WORD_BITS-1:0]  new_val,
    output logic [WORD_BITS-1:0]  old_val,
    output logic [WORD_BITS-1:0]  wr_lo,
    output logic [WORD_BITS-1:0]  wr_hi,
    output logic [WORD_BYTES-1:0] strb_lo,
    output logic [WORD_BYTES-1:0] strb_hi
);
    logic [2*WORD_BITS-1:0]  window;
    logic [2*WORD_BITS-1:0]  aligned;
    logic [2*WORD_BITS-1:0]  placed;
    logic [2*WORD_BYTES-1:0] bmask;
    logic [5:0]              bit_off;

    always_comb begin
        bit_off = {off, 3'b000};
        window  = {hi_word, lo_word};
        aligned = window >> bit_off;
        old_val = aligned[WORD_BITS-1:0] & data_mask(size);
        placed  = {{WORD_BITS{1'b0}}, new_val & data_mask(size)} << bit_off;
        bmask   = {{WORD_BYTES{1'b0}}, byte_mask(size)} << off;
        wr_lo   = placed[WORD_BITS-1:0];
        wr_hi   = placed[2*WORD_BITS-1:WORD_BITS];
        strb_lo = bmask[WORD_BYTES-1:0];
        strb_hi = bmask[2*WORD_BYTES-1:WORD_BYTES];
    end
endmodule

// File: rtl/amo_lock_unit.sv
module amo_lock_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 64,
    parameter int CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [2:0]              req_op,
    input  logic                    req_lock,
    input  logic [1:0]              req_size,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [63:0]             req_operand,
    input  logic [63:0]             req_expect,
    output logic                    resp_valid,
    output logic [63:0]             resp_old,
    output logic                    resp_ok,
    output logic                    resp_err,
    output logic                    resp_split,
    output logic [CNT_W-1:0]        split_count,
    output logic                    bus_lock,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-4:0]       mem_addr,
    output logic [63:0]             mem_wdata,
    output logic [7:0]              mem_wstrb,
    input  logic                    mem_ack,
    input  logic [63:0]             mem_rdata
);
    localparam int WIDX_W = ADDR_W - OFF_W;

    amo_state_e           state;
    amo_ctl_t             ctl;
    logic [WIDX_W-1:0]    widx_q;
    logic [WORD_BITS-1:0] opnd_q;
    logic [WORD_BITS-1:0] exp_q;
    logic [WORD_BITS-1:0] lo_q;
    logic [WORD_BITS-1:0] hi_q;
    logic                 err_q;
    logic [CNT_W-1:0]     split_q;

    amo_op_e              op_in;
    logic [OFF_W-1:0]     dec_off;
    logic [WIDX_W-1:0]    dec_widx;
    logic                 dec_two;
    logic                 dec_split;
    logic                 reject;
    logic                 want_lock;

    logic [WORD_BITS-1:0]  old_val;
    logic [WORD_BITS-1:0]  new_val;
    logic                  cas_hit;
    logic [WORD_BITS-1:0]  wr_lo;
    logic [WORD_BITS-1:0]  wr_hi;
    logic [WORD_BYTES-1:0] strb_lo;
    logic [WORD_BYTES-1:0] strb_hi;

    amo_addr_decode #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_dec (
        .addr     (req_addr),
        .size     (req_size),
        .off      (dec_off),
        .widx     (dec_widx),
        .two_word (dec_two),
        .split    (dec_split)
    );

    amo_lane u_lane (
        .off     (ctl.off),
        .size    (ctl.size),
        .lo_word (lo_q),
        .hi_word (hi_q),
        .new_val (new_val),
        .old_val (old_val),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .strb_lo (strb_lo),
        .strb_hi (strb_hi)
    );

    amo_alu u_alu (
        .op       (ctl.op),
        .size     (ctl.size),
        .old_val  (old_val),
        .operand  (opnd_q),
        .expect_v (exp_q),
        .new_val  (new_val),
        .cas_hit  (cas_hit)
    );

    always_comb begin
        op_in     = amo_op_e'(req_op);
        reject    = req_lock && is_plain(op_in);
        want_lock = req_lock || (op_in == OP_SWAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl     <= '0;
            widx_q  <= '0;
            opnd_q  <= '0;
            exp_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            err_q   <= 1'b0;
            split_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctl.op       <= op_in;
                        ctl.size     <= req_size;
                        ctl.off      <= dec_off;
                        ctl.two_word <= dec_two;
                        ctl.split    <= dec_split && !reject;
                        ctl.locked   <= want_lock && !reject;
                        widx_q       <= dec_widx;
                        opnd_q       <= req_operand;
                        exp_q        <= req_expect;
                        lo_q         <= '0;
                        hi_q         <= '0;
                        err_q        <= reject;
                        if (dec_split && !reject) begin
                            split_q <= split_q + 1'b1;
                        end
                        if (reject) begin
                            state <= ST_DONE;
                        end else if (want_lock) begin
                            state <= ST_LOCK;
                        end else if (op_in == OP_STORE) begin
                            state <= ST_WR0;
                        end else begin
                            state <= ST_RD0;
                        end
                    end
                end
                ST_LOCK: state <= ST_RD0;
                ST_RD0: begin
                    if (mem_ack) begin
                        lo_q <= mem_rdata;
                        if (ctl.two_word) begin
                            state <= ST_RD1;
                        end else if (ctl.op == OP_LOAD) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_WR0;
                        end
                    end
                end
                ST_RD1: begin
                    if (mem_ack) begin
                        hi_q  <= mem_rdata;
                        state <= (ctl.op == OP_LOAD) ? ST_DONE : ST_WR0;
                    end
                end
                ST_WR0: begin
                    if (mem_ack) begin
                        state <= ctl.two_word ? ST_WR1 : ST_DONE;
                    end
                end
                ST_WR1: begin
                    if (mem_ack) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (state == ST_IDLE);
        mem_req     = (state == ST_RD0) || (state == ST_RD1) ||
                      (state == ST_WR0) || (state == ST_WR1);
        mem_we      = (state == ST_WR0) || (state == ST_WR1);
        bus_lock    = ctl.locked && ((state == ST_LOCK) || mem_req);
        mem_addr    = ((state == ST_RD1) || (state == ST_WR1)) ? widx_q + 1'b1 : widx_q;
        mem_wdata   = (state == ST_WR1) ? wr_hi : wr_lo;
        mem_wstrb   = (state == ST_WR1) ? strb_hi : strb_lo;
        resp_valid  = (state == ST_DONE);
        resp_old    = old_val;
        resp_err    = err_q;
        resp_ok     = !err_q && ((ctl.op != OP_CAS) || cas_hit);
        resp_split  = ctl.split;
        split_count = split_q;
    end
endmodule

// File: rtl/amo_lock_unit_chk.sv
module amo_lock_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_ok,
    input logic             resp_err,
    input logic             resp_split,
    input logic [CNT_W-1:0] split_count,
    input logic             bus_lock,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack
);
    // R1: the lock is raised in a cycle with no beat outstanding
    p_lock_before_read_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_lock) |-> !mem_req);

    // R1: a read acknowledged under lock is followed by more locked cycles
    p_lock_kept_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_lock && mem_req && mem_ack && !mem_we) |=> bus_lock);

    // R1: the lock only drops together with the response
    p_lock_fall_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_lock) |-> resp_valid);

    // R6: a rejected request never reports success or a split
    p_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> (!resp_ok && !resp_split));

    // R10: idle unit drives neither a beat nor the lock
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req && !bus_lock));

    // R8: the split counter moves only on an accepted request
    p_split_step_r8: assert property (@(posedge clk) disable iff (rst)
        (split_count != $past(split_count)) |-> $past(req_valid && req_ready));

    // R12: response is a one-cycle pulse
    p_resp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
endmodule

bind amo_lock_unit amo_lock_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_ok     (resp_ok),
    .resp_err    (resp_err),
    .resp_split  (resp_split),
    .split_count (split_count),
    .bus_lock    (bus_lock),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack)
);

// File: tb/sim_amo_lock_unit.sv
`timescale 1ns/1ps
module sim_amo_lock_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        vld   [2];
    logic        rdy   [2];
    logic [2:0]  rop   [2];
    logic        rlk   [2];
    logic [1:0]  rsz   [2];
    logic [15:0] radr  [2];
    logic [63:0] ropn  [2];
    logic [63:0] rexp  [2];
    logic        rv    [2];
    logic [63:0] rold  [2];
    logic        rok   [2];
    logic        rerr  [2];
    logic        rspl  [2];
    logic [15:0] scnt  [2];
    logic        lock  [2];
    logic        mreq  [2];
    logic        mwe   [2];
    logic [12:0] maddr [2];
    logic [63:0] mwdat [2];
    logic [7:0]  mstrb [2];
    logic        mack  [2];
    logic [63:0] mrdata;

    logic [63:0] mem [256];
    logic        ack_q;
    logic        ack_port;
    logic        owner;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int lock_cyc [2];
    int acks     [2];
    int nolk     [2];

    amo_lock_unit u0 (
        .clk(clk), .rst(rst), .req_valid(vld[0]), .req_ready(rdy[0]), .req_op(rop[0]),
        .req_lock(rlk[0]), .req_size(rsz[0]), .req_addr(radr[0]), .req_operand(ropn[0]),
        .req_expect(rexp[0]), .resp_valid(rv[0]), .resp_old(rold[0]), .resp_ok(rok[0]),
        .resp_err(rerr[0]), .resp_split(rspl[0]), .split_count(scnt[0]), .bus_lock(lock[0]),
        .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwdat[0]),
        .mem_wstrb(mstrb[0]), .mem_ack(mack[0]), .mem_rdata(mrdata));

    amo_lock_unit u1 (
        .clk(clk), .rst(rst), .req_valid(vld[1]), .req_ready(rdy[1]), .req_op(rop[1]),
        .req_lock(rlk[1]), .req_size(rsz[1]), .req_addr(radr[1]), .req_operand(ropn[1]),
        .req_expect(rexp[1]), .resp_valid(rv[1]), .resp_old(rold[1]), .resp_ok(rok[1]),
        .resp_err(rerr[1]), .resp_split(rspl[1]), .split_count(scnt[1]), .bus_lock(lock[1]),
        .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwdat[1]),
        .mem_wstrb(mstrb[1]), .mem_ack(mack[1]), .mem_rdata(mrdata));

    // Shared memory with a round-robin arbiter that keeps a locked owner granted
    always @(posedge clk) begin
        if (rst) begin
            ack_q    <= 1'b0;
            ack_port <= 1'b0;
            owner    <= 1'b0;
        end else if (ack_q) begin
            ack_q <= 1'b0;
        end else if (mreq[owner]) begin
            ack_q    <= 1'b1;
            ack_port <= owner;
            if (mwe[owner]) begin
                for (int b = 0; b < 8; b++) begin
                    if (mstrb[owner][b]) mem[maddr[owner][7:0]][b*8 +: 8] <= mwdat[owner][b*8 +: 8];
                end
            end else begin
                mrdata <= mem[maddr[owner][7:0]];
            end
        end else if (!lock[owner] && (mreq[!owner] || lock[!owner])) begin
            owner <= !owner;
        end
    end
    assign mack[0] = ack_q && !ack_port;
    assign mack[1] = ack_q && ack_port;

    always @(negedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (lock[p]) lock_cyc[p]++;
            if (mack[p]) begin
                acks[p]++;
                if (!lock[p]) nolk[p]++;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic run_op(input int p, input logic [2:0] op, input logic lk, input logic [1:0] sz,
                          input logic [15:0] addr, input logic [63:0] opnd, input logic [63:0] expv,
                          output logic [63:0] old, output logic ok, output logic err, output logic spl);
        int waitc;
        @(negedge clk);
        while (!rdy[p]) @(negedge clk);
        lock_cyc[p] = 0; acks[p] = 0; nolk[p] = 0;
        vld[p] = 1'b1; rop[p] = op; rlk[p] = lk; rsz[p] = sz;
        radr[p] = addr; ropn[p] = opnd; rexp[p] = expv;
        @(negedge clk);
        vld[p] = 1'b0;
        waitc = 0;
        while (!rv[p] && waitc < 2000) begin
            @(negedge clk);
            waitc++;
        end
        chk(rv[p], "R12 response arrives", 64'(rv[p]), 64'd1);
        old = rold[p]; ok = rok[p]; err = rerr[p]; spl = rspl[p];
        @(negedge clk);
        chk(!rv[p], "R12 pulse width", 64'(rv[p]), 64'd0);
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic        lk;
        logic [1:0]  sz;
        logic [15:0] addr;
        logic [63:0] opnd;
        logic [63:0] expv;
        logic [63:0] init;
        logic [63:0] old;
        logic        ok;
        logic [63:0] mem;
    } vec_t;

    localparam logic [63:0] W = 64'h1122_3344_5566_7788;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 1'b1, 2'd3, 16'd16, 64'h1,          64'h0,         W, W,             1'b1, 64'h1122_3344_5566_7789}, // R4
        '{3'd2, 1'b0, 2'd2, 16'd20, 64'hDEAD_BEEF,  64'h0,         W, 64'h1122_3344, 1'b1, 64'hDEAD_BEEF_5566_7788}, // R2
        '{3'd4, 1'b1, 2'd3, 16'd16, 64'h5,          W,             W, W,             1'b1, 64'h5},                   // R3 hit
        '{3'd4, 1'b1, 2'd3, 16'd16, 64'h5,          64'h0,         W, W,             1'b0, W},                       // R3 miss
        '{3'd5, 1'b0, 2'd1, 16'd18, 64'h0F0F,       64'h0,         W, 64'h5566,      1'b1, 64'h1122_3344_0506_7788}, // R5 AND
        '{3'd6, 1'b1, 2'd0, 16'd23, 64'h80,         64'h0,         W, 64'h11,        1'b1, 64'h9122_3344_5566_7788}, // R5 OR
        '{3'd7, 1'b1, 2'd2, 16'd16, 64'hFFFF_FFFF,  64'h0,         W, 64'h5566_7788, 1'b1, 64'h1122_3344_AA99_8877}, // R5 XOR
        '{3'd3, 1'b1, 2'd0, 16'd16, 64'h80,         64'h0,         W, 64'h88,        1'b1, 64'h1122_3344_5566_7708}, // R4 wrap byte
        '{3'd3, 1'b1, 2'd1, 16'd16, 64'h8878,       64'h0,         W, 64'h7788,      1'b1, 64'h1122_3344_5566_0000}, // R4 wrap half
        '{3'd0, 1'b0, 2'd3, 16'd16, 64'h0,          64'h0,         W, W,             1'b1, W},                       // R7 load
        '{3'd4, 1'b1, 2'd2, 16'd20, 64'h0BAD_F00D,  64'h1122_3344, W, 64'h1122_3344, 1'b1, 64'h0BAD_F00D_5566_7788}, // R3 word
        '{3'd1, 1'b0, 2'd1, 16'd22, 64'hCAFE,       64'h0,         W, 64'h0,         1'b1, 64'hCAFE_3344_5566_7788}  // R12 store
    };

    localparam int NCONC = 25;

    initial begin
        logic [63:0] old;
        logic ok, err, spl;
        for (int p = 0; p < 2; p++) begin
            vld[p] = 0; rop[p] = 0; rlk[p] = 0; rsz[p] = 0; radr[p] = 0; ropn[p] = 0; rexp[p] = 0;
            lock_cyc[p] = 0; acks[p] = 0; nolk[p] = 0;
        end
        for (int i = 0; i < 256; i++) mem[i] = 64'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk(rdy[0] == 1'b1, "R10 ready after reset", 64'(rdy[0]), 64'd1);
        chk(lock[0] == 1'b0, "R10 lock after reset", 64'(lock[0]), 64'd0);
        chk(mreq[0] == 1'b0, "R10 mem_req after reset", 64'(mreq[0]), 64'd0);
        chk(rv[0] == 1'b0, "R10 resp_valid after reset", 64'(rv[0]), 64'd0);
        chk(scnt[0] == 16'd0, "R10 split_count after reset", 64'(scnt[0]), 64'd0);

        // R1: cycle-exact lock timing for a locked one-word add
        mem[2] = W;
        vld[0] = 1'b1; rop[0] = 3'd3; rlk[0] = 1'b1; rsz[0] = 2'd3; radr[0] = 16'd16; ropn[0] = 64'd2;
        @(negedge clk);
        vld[0] = 1'b0;
        chk(lock[0] && !mreq[0], "R1 lock rises before read", {62'd0, lock[0], mreq[0]}, 64'h2);
        @(negedge clk);
        chk(lock[0] && mreq[0] && !mwe[0], "R1 read beat locked", {61'd0, lock[0], mreq[0], mwe[0]}, 64'h6);
        @(negedge clk);
        chk(lock[0] && mack[0], "R1 read ack locked", {62'd0, lock[0], mack[0]}, 64'h3);
        @(negedge clk);
        chk(lock[0] && mreq[0] && mwe[0], "R1 write beat locked", {61'd0, lock[0], mreq[0], mwe[0]}, 64'h7);
        @(negedge clk);
        chk(lock[0] && mack[0], "R1 write ack locked", {62'd0, lock[0], mack[0]}, 64'h3);
        @(negedge clk);
        chk(!lock[0] && rv[0], "R1 lock falls with response", {62'd0, lock[0], rv[0]}, 64'h1);
        chk(rold[0] == W, "R4 add old value", rold[0], W);
        @(negedge clk);
        chk(mem[2] == W + 64'd2, "R4 add memory", mem[2], W + 64'd2);

        // Vector table: R2 R3 R4 R5 R7 R12
        for (int v = 0; v < NV; v++) begin
            mem[2] = VECS[v].init;
            run_op(0, VECS[v].op, VECS[v].lk, VECS[v].sz, VECS[v].addr, VECS[v].opnd, VECS[v].expv, old, ok, err, spl);
            chk(old == VECS[v].old, $sformatf("R2-5 vec%0d old", v), old, VECS[v].old);
            chk(ok == VECS[v].ok, $sformatf("R3 vec%0d ok flag", v), 64'(ok), 64'(VECS[v].ok));
            chk(mem[2] == VECS[v].mem, $sformatf("R4 vec%0d memory", v), mem[2], VECS[v].mem);
            chk((lock_cyc[0] > 0) == (VECS[v].lk || VECS[v].op == 3'd2),
                $sformatf("R7 vec%0d lock use", v), 64'(lock_cyc[0]), 64'(VECS[v].lk || VECS[v].op == 3'd2));
        end

        // R6: locked load and store are rejected without memory access
        mem[2] = W;
        run_op(0, 3'd0, 1'b1, 2'd3, 16'd16, 64'h0, 64'h0, old, ok, err, spl);
        chk(err && !ok, "R6 locked load rejected", {62'd0, err, ok}, 64'h2);
        chk(acks[0] == 0 && lock_cyc[0] == 0, "R6 locked load no beats", 64'(acks[0] + lock_cyc[0]), 64'd0);
        run_op(0, 3'd1, 1'b1, 2'd3, 16'd16, 64'h1234, 64'h0, old, ok, err, spl);
        chk(err && !ok, "R6 locked store rejected", {62'd0, err, ok}, 64'h2);
        chk(mem[2] == W, "R6 locked store leaves memory", mem[2], W);
        chk(scnt[0] == 16'd0, "R8 reject not counted", 64'(scnt[0]), 64'd0);

        // R8: locked split add across line 0/1
        mem[7] = 64'hAABB_0000_0000_0000;
        mem[8] = 64'h0000_0000_0000_DDCC;
        run_op(0, 3'd3, 1'b1, 2'd2, 16'd62, 64'h1, 64'h0, old, ok, err, spl);
        chk(old == 64'hDDCC_AABB, "R8 split old value", old, 64'hDDCC_AABB);
        chk(spl == 1'b1, "R8 split flag", 64'(spl), 64'd1);
        chk(scnt[0] == 16'd1, "R8 split count one", 64'(scnt[0]), 64'd1);
        chk(acks[0] == 4 && nolk[0] == 0, "R8 four locked beats", 64'(acks[0] * 16 + nolk[0]), 64'd64);
        chk(mem[7] == 64'hAABC_0000_0000_0000, "R8 split low word", mem[7], 64'hAABC_0000_0000_0000);
        chk(mem[8] == 64'h0000_0000_0000_DDCC, "R8 split high word", mem[8], 64'h0000_0000_0000_DDCC);
        run_op(0, 3'd2, 1'b0, 2'd3, 16'd60, 64'h0102_0304_0506_0708, 64'h0, old, ok, err, spl);
        chk(old == 64'h0000_DDCC_AABC_0000, "R8 split swap old", old, 64'h0000_DDCC_AABC_0000);
        chk(scnt[0] == 16'd2, "R8 split count two", 64'(scnt[0]), 64'd2);
        chk(mem[7] == 64'h0506_0708_0000_0000, "R8 split swap low", mem[7], 64'h0506_0708_0000_0000);
        chk(mem[8] == 64'h0000_0000_0102_0304, "R8 split swap high", mem[8], 64'h0000_0000_0102_0304);

        // R9: word crossing inside one line
        mem[1] = 64'h2211_0000_0000_0000;
        mem[2] = 64'hFFFF_FFFF_FFFF_4433;
        run_op(0, 3'd2, 1'b0, 2'd2, 16'd14, 64'h0102_0304, 64'h0, old, ok, err, spl);
        chk(old == 64'h4433_2211, "R9 crossing old value", old, 64'h4433_2211);
        chk(!spl && scnt[0] == 16'd2, "R9 not a split", {47'd0, spl, scnt[0]}, 64'd2);
        chk(acks[0] == 4, "R9 four beats", 64'(acks[0]), 64'd4);
        chk(mem[1] == 64'h0304_0000_0000_0000, "R9 low word bytes", mem[1], 64'h0304_0000_0000_0000);
        chk(mem[2] == 64'hFFFF_FFFF_FFFF_0102, "R9 high word bytes", mem[2], 64'hFFFF_FFFF_FFFF_0102);

        // R11: concurrent locked increments from two units
        mem[10] = 64'h0;
        fork
            begin
                logic [63:0] o0; logic k0, e0, s0;
                for (int i = 0; i < NCONC; i++) run_op(0, 3'd3, 1'b1, 2'd2, 16'd80, 64'h1, 64'h0, o0, k0, e0, s0);
            end
            begin
                logic [63:0] o1; logic k1, e1, s1;
                for (int i = 0; i < NCONC; i++) run_op(1, 3'd3, 1'b1, 2'd2, 16'd80, 64'h1, 64'h0, o1, k1, e1, s1);
            end
        join
        repeat (2) @(negedge clk);
        chk(mem[10] == 64'(2 * NCONC), "R11 no lost increments", mem[10], 64'(2 * NCONC));

        finish_run();
    end
endmodule